// File: doc/BRIEF.md
# Sync-Triggered Parallel Video Output Port

This block drives pixel samples onto an 8-bit parallel bus toward a display panel, paced entirely by two external active-low synchronisation inputs: a line sync and a frame sync. Pixel data arrives as 16-bit words on a valid/ready stream. Each word is split into two 8-bit samples, low byte first.

The frame sync arms the port. Once armed, a falling edge on the line sync starts a fixed wait of `DELAY` clocks. After the wait, the port drives exactly `SAMPLES` samples, one per clock, and then returns to idle until the next line-sync edge. When no word is available at a sample slot that needs one, the port repeats the previous bus value and raises an underrun indication for that sample. Outside the active window the bus is held at zero and the stream is not accepted.

The port is enabled before the external sync generators are started, so the first frame-sync edge it sees aligns it to a frame boundary. Generating the syncs and fetching data from memory are done elsewhere.

Top module: `vport_top`

## Requirements
- R1: During and after reset, `pix_valid`, `pix_data`, `underrun` and `in_ready` are all zero.
- R2: A line-sync falling edge starts a line only if the port is armed. The port becomes armed on the clock after a frame-sync falling edge is sampled while `enable` is high. Line-sync edges seen before that are ignored.
- R3: A falling edge is seen at the clock edge where the sync input is sampled low after being sampled high. The reset value counts as high. If that clock edge is N, `pix_valid` first rises at clock edge N + `DELAY`. `DELAY` is at least 1.
- R4: Each accepted line yields exactly `SAMPLES` consecutive cycles with `pix_valid` high, then the port goes idle.
- R5: Each 16-bit word is consumed when `in_valid` and `in_ready` are both high at a clock edge. Its bits [7:0] are driven at that edge and its bits [15:8] at the following sample. The first sample of every line uses a new word.
- R6: `in_ready` is high only in cycles whose next clock edge drives a sample that needs a new word.
- R7: If a new word is needed but `in_valid` is low, the sample repeats the previous `pix_data` value and `underrun` is high with it. No word is consumed, and the next sample again asks for a new word.
- R8: Outside the active window, `pix_data` is zero and `pix_valid`, `underrun` and `in_ready` are low.
- R9: Line-sync edges that arrive during the wait or during the active window are ignored. They neither restart nor extend the line.
- R10: Pulling `enable` low returns the port to idle and disarms it. A new frame-sync edge is then needed before any line starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Port enable; low forces idle and disarms |
| line_sync_n | input | 1 | Active-low line sync, falling edge starts a line |
| frame_sync_n | input | 1 | Active-low frame sync, falling edge arms the port |
| in_data | input | 16 | Pixel word: two samples, low byte first |
| in_valid | input | 1 | Word available on `in_data` |
| in_ready | output | 1 | Port takes the word at this clock edge |
| pix_data | output | 8 | Sample bus toward the panel |
| pix_valid | output | 1 | A sample is driven this cycle |
| underrun | output | 1 | This sample is a repeat because no word was available |

## Verification
The assertions take for granted that `in_data` stays stable while `in_valid` is high and `in_ready` is low. They also assume that `enable` does not toggle back high within one clock of going low. The bench drives the stream from an index that advances only on a completed handshake, so `in_data` never changes under a pending word. It changes `enable` only with idle gaps of several cycles. The sync inputs are driven as single-cycle pulses at the falling clock edge, which keeps every edge cleanly sampled.

// File: rtl/vport_pkg.sv
// Package: shared types for the sync-triggered video output port.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package vport_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACT  = 2'd2
    } vport_state_t;
endpackage

// File: rtl/vport_edge.sv
// Module: falling-edge detector for one active-low sync input.
// Assumes: sync input already synchronous to clk; reset value counts as high.
module vport_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    output logic fall
);
    logic prev_q;

    // Remember the previous sampled level of the sync.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_n;
    end

    // Falling edge: high last cycle, low now.
    always_comb fall = prev_q & ~sync_n;
endmodule

// File: rtl/vport_seq.sv
// Module: line sequencer. Arms on a frame-sync edge, waits DELAY clocks
// after an accepted line-sync edge, then marks SAMPLES emission cycles.
// Assumes: DELAY >= 1 and SAMPLES >= 1.
module vport_seq
    import vport_pkg::*;
#(
    parameter int DELAY   = 204,
    parameter int SAMPLES = 960
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic line_fall,
    input  logic frame_fall,
    output logic emit,
    output logic line_first
);
    localparam int DW = $clog2(DELAY + 1);
    localparam int SW = $clog2(SAMPLES + 1);

    vport_state_t   st;
    logic [DW-1:0]  wcnt;
    logic [SW-1:0]  left;
    logic           armed;

    // Emission strobes derived from the current state.
    always_comb begin
        line_first = (st == ST_WAIT) && (wcnt == '0);
        emit       = line_first || (st == ST_ACT);
    end

    // State, wait counter, sample counter and arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            wcnt  <= '0;
            left  <= '0;
            armed <= 1'b0;
        end else if (!enable) begin
            st    <= ST_IDLE;
            armed <= 1'b0;
        end else begin
            if (frame_fall) armed <= 1'b1;
            case (st)
                ST_IDLE: begin
                    if (line_fall && armed) begin
                        st   <= ST_WAIT;
                        wcnt <= DW'(DELAY - 1);
                    end
                end
                ST_WAIT: begin
                    if (wcnt == '0) begin
                        left <= SW'(SAMPLES - 1);
                        st   <= (SAMPLES == 1) ? ST_IDLE : ST_ACT;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                ST_ACT: begin
                    left <= left - 1'b1;
                    if (left == SW'(1)) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vport_unpack.sv
// Module: splits input words into two samples, low half first, and
// drives the registered sample bus. Repeats the last sample on underrun.
// Assumes: emit/line_first come from vport_seq in the same clock domain.
module vport_unpack #(
    parameter int SAMPLE_W = 8,
    localparam int WORD_W  = 2 * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                emit,
    input  logic                line_first,
    input  logic [WORD_W-1:0]   in_data,
    input  logic                in_valid,
    output logic                in_ready,
    output logic [SAMPLE_W-1:0] pix_data,
    output logic                pix_valid,
    output logic                underrun
);
    logic                hi_q;
    logic [SAMPLE_W-1:0] held_q;
    logic                need_word;

    // A new word is needed for the first sample of a line or after a high half.
    always_comb begin
        need_word = line_first || !hi_q;
        in_ready  = emit && need_word;
    end

    // Sample bus, held upper half and underrun strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q      <= 1'b0;
            held_q    <= '0;
            pix_data  <= '0;
            pix_valid <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            pix_valid <= emit;
            underrun  <= 1'b0;
            if (!emit) begin
                pix_data <= '0;
                hi_q     <= 1'b0;
            end else if (need_word) begin
                if (in_valid) begin
                    pix_data <= in_data[SAMPLE_W-1:0];
                    held_q   <= in_data[WORD_W-1:SAMPLE_W];
                    hi_q     <= 1'b1;
                end else begin
                    underrun <= 1'b1;
                    hi_q     <= 1'b0;
                end
            end else begin
                pix_data <= held_q;
                hi_q     <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vport_top.sv
// Module: sync-triggered parallel video output port (top).
// Detects falling edges on both syncs, sequences the delayed active
// window and unpacks 16-bit words onto the 8-bit sample bus.
// Assumes: syncs and stream synchronous to clk; DELAY >= 1.
module vport_top #(
    parameter int DELAY   = 204,
    parameter int SAMPLES = 960
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        line_sync_n,
    input  logic        frame_sync_n,
    input  logic [15:0] in_data,
    input  logic        in_valid,
    output logic        in_ready,
    output logic [7:0]  pix_data,
    output logic        pix_valid,
    output logic        underrun
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] sync_n;
    logic [NSYNC-1:0] sync_fall;
    logic             emit;
    logic             line_first;

    // Bundle the syncs: bit 0 line, bit 1 frame.
    always_comb sync_n = {frame_sync_n, line_sync_n};

    // One edge detector per sync input.
    for (genvar g = 0; g < NSYNC; g++) begin : g_edge
        vport_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_n (sync_n[g]),
            .fall   (sync_fall[g])
        );
    end

    vport_seq #(.DELAY(DELAY), .SAMPLES(SAMPLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .line_fall  (sync_fall[0]),
        .frame_fall (sync_fall[1]),
        .emit       (emit),
        .line_first (line_first)
    );

    vport_unpack #(.SAMPLE_W(8)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .emit       (emit),
        .line_first (line_first),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .pix_data   (pix_data),
        .pix_valid  (pix_valid),
        .underrun   (underrun)
    );
endmodule

// File: rtl/vport_checker.sv
// Module: property checker for vport_top, attached by bind.
// Assumes: in_data stable while a word waits; enable low lasts >= 2 cycles.
module vport_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic [15:0] in_data,
    input logic        in_valid,
    input logic        in_ready,
    input logic [7:0]  pix_data,
    input logic        pix_valid,
    input logic        underrun
);
    // R8: idle bus carries zero.
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> (pix_data == 8'h00) && !underrun);

    // R6: ready is only offered for a sample driven at the next edge.
    assert_ready_emits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> pix_valid);

    // R5: an accepted word puts its low half on the bus first.
    assert_low_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> pix_valid && !underrun && (pix_data == $past(in_data[7:0])));

    // R7: an underrun sample repeats the previous bus value.
    assert_underrun_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> pix_valid && $stable(pix_data));

    // R7: a missing word causes an underrun on the next sample.
    assert_missing_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> underrun);

    // R10: disabling the port empties the bus within two edges.
    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |=> !pix_valid);
endmodule

bind vport_top vport_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .pix_data  (pix_data),
    .pix_valid (pix_valid),
    .underrun  (underrun)
);

// File: tb/sim_vport_top.sv
// Bench: directed scenarios for vport_top, each task checking its results.
module sim_vport_top;
    localparam int DELAY   = 5;
    localparam int SAMPLES = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        line_sync_n = 1'b1;
    logic        frame_sync_n = 1'b1;
    logic [15:0] in_data;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  pix_data;
    logic        pix_valid;
    logic        underrun;

    int nchk = 0;
    int nfail = 0;
    int idx = 0;
    int limit = 1000;

    always #2 clk = ~clk;  // 250 MHz

    // Stream source: word i carries samples 0xA0+2i (low) and 0xA1+2i (high).
    assign in_valid = (idx < limit);
    assign in_data  = {8'(8'hA1 + 2 * idx), 8'(8'hA0 + 2 * idx)};
    always @(posedge clk) if (rst_n && in_ready && in_valid) idx <= idx + 1;

    vport_top #(.DELAY(DELAY), .SAMPLES(SAMPLES)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .line_sync_n(line_sync_n), .frame_sync_n(frame_sync_n),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .pix_data(pix_data), .pix_valid(pix_valid), .underrun(underrun)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(!pix_valid && pix_data == 8'h00 && !underrun && !in_ready, req,
            {pix_valid, underrun, in_ready, pix_data}, 0);
    endtask

    task automatic pulse_frame();
        frame_sync_n = 1'b0;
        tick();
        frame_sync_n = 1'b1;
        tick();
    endtask

    // One line: base = first expected sample, good = samples before underrun,
    // retrig = sample index at which a spurious line edge is driven (-1 none).
    task automatic run_line(input int base, input int good, input int retrig);
        line_sync_n = 1'b0;
        tick();                     // edge N
        line_sync_n = 1'b1;
        for (int i = 1; i < DELAY; i++) begin
            chk(!pix_valid, "R3 still waiting", pix_valid, 0);
            tick();
        end
        chk(!pix_valid, "R3 last wait cycle", pix_valid, 0);
        chk(in_ready == in_valid || in_ready, "R6 ready before first sample", in_ready, 1);
        for (int s = 0; s < SAMPLES; s++) begin
            tick();                 // edge N+DELAY+s
            line_sync_n = (s == retrig) ? 1'b0 : 1'b1;
            chk(pix_valid, "R4 sample valid", pix_valid, 1);
            if (s < good) begin
                chk(pix_data == 8'(base + s) && !underrun, "R5 sample order",
                    pix_data, 8'(base + s));
            end else begin
                chk(pix_data == 8'(base + good - 1) && underrun, "R7 underrun repeat",
                    {underrun, pix_data}, {1'b1, 8'(base + good - 1)});
            end
        end
        line_sync_n = 1'b1;
        tick();
        chk_idle("R4 idle after window");
        tick();
        chk_idle("R8 bus zero outside window");
    endtask

    task automatic t_reset();
        chk_idle("R1 reset state");
        tick();
        chk_idle("R1 after reset edge");
    endtask

    task automatic t_unarmed();
        line_sync_n = 1'b0;
        tick();
        line_sync_n = 1'b1;
        for (int i = 0; i < DELAY + SAMPLES + 2; i++) begin
            chk_idle("R2 line edge ignored while unarmed");
            tick();
        end
    endtask

    task automatic t_lines();
        pulse_frame();
        run_line(8'hA0 + 2 * idx, SAMPLES, -1);
        run_line(8'hA0 + 2 * idx, SAMPLES, -1);
    endtask

    task automatic t_underrun();
        limit = idx + 1;
        run_line(8'hA0 + 2 * idx, 2, -1);
        chk(idx == limit, "R7 no word consumed", idx, limit);
        limit = 1000;
    endtask

    task automatic t_retrigger();
        run_line(8'hA0 + 2 * idx, SAMPLES, 2);
        for (int i = 0; i < DELAY + 3; i++) begin
            tick();
            chk_idle("R9 edge in window ignored");
        end
    endtask

    task automatic t_disable();
        enable = 1'b0;
        tick();
        tick();
        enable = 1'b1;
        tick();
        line_sync_n = 1'b0;
        tick();
        line_sync_n = 1'b1;
        for (int i = 0; i < DELAY + SAMPLES; i++) begin
            chk_idle("R10 disarmed after disable");
            tick();
        end
        pulse_frame();
        run_line(8'hA0 + 2 * idx, SAMPLES, -1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        enable = 1'b1;
        tick();
        t_unarmed();
        t_lines();
        t_underrun();
        t_retrigger();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule